// File: doc/BRIEF.md
# Sixteen-bit dual-stack processor core

This core runs 16-bit instruction words from a word-addressed program memory. Its working state is a top-of-stack register T, a 16-entry data stack whose top entry is the second operand N, and a 16-entry return stack. A register R reads the top of the return stack. A program counter of 13 bits selects the next word.

Every instruction falls into one of five classes: literal push, jump, jump-if-zero, call, or ALU. An ALU word holds several fields side by side: a result select for T, a set of transfer enables (T into N, T onto the return stack, N stored at address T), two small stack-pointer deltas and a return bit. One such word can compute, move data and return from a subroutine in the same cycle.

The instruction memory is synchronous. The core presents the address of the next word, and that word arrives one clock later. The data memory takes its address from T and its write data from N. Its read data must be valid in the same cycle as its address.

Top module: `scpu_core`

## Requirements
- R1: While rst_ni is low, imem_addr_o, dmem_addr_o and dmem_wdata_o read zero and dmem_we_o is low. In the first cycle after release, imem_addr_o stays 0 and nothing is stored. The word at address 0 executes in the second cycle after release.
- R2: A word with bit 15 set pushes bits 14:0, zero-extended, as the new T. The old T becomes N.
- R3: A word with bits 15:13 = 000 jumps to bits 12:0 and leaves T, N and both stacks unchanged.
- R4: A word with bits 15:13 = 001 always pops: N becomes T. It branches to bits 12:0 only if T was zero before the pop; otherwise it continues at PC+1.
- R5: A word with bits 15:13 = 010 pushes PC+1 onto the return stack and jumps to bits 12:0. In an ALU word (bits 15:13 = 011), bit 12 set loads the PC from R.
- R6: ALU result select in bits 11:8: 0 gives T, 1 gives N, 2 gives N+T, 3 gives N&T, 4 gives N|T, 5 gives N^T, 6 gives ~T, 9 gives T shifted right by one (logical), A gives T-1, D gives T shifted left by one.
- R7: Codes 7 (N==T), 8 (N<T signed) and F (N<T unsigned) give 16'hFFFF when true and 0 when false.
- R8: Code B gives R, code C gives the data-memory word at address T, and code E gives the data-stack pointer plus one.
- R9: In ALU words, bit 4 writes the old T into the data stack at the new pointer, and bit 5 writes it into the return stack at the new pointer. Bit 6 asserts dmem_we_o with address T and data N. Bit 7 has no effect. No other class stores.
- R10: Bits 1:0 and 3:2 are two's-complement deltas for the data and return stack pointers. A literal adds +1 to the data pointer and a conditional jump adds -1. Pointers wrap modulo 16, and reset sets both to zero.
- R11: Each instruction completes in one cycle. imem_addr_o shows the address of the next instruction during the cycle in which the current one executes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| imem_addr_o | output | 13 | Program memory word address for the next fetch |
| imem_data_i | input | 16 | Instruction word, one cycle after its address |
| dmem_addr_o | output | 16 | Data memory address (current T) |
| dmem_wdata_o | output | 16 | Data memory write data (current N) |
| dmem_we_o | output | 1 | Data memory write strobe |
| dmem_rdata_i | input | 16 | Data memory read data at dmem_addr_o, same cycle |

## Verification
Program-counter results appear on imem_addr_o in the same cycle as the instruction that produces them. Stores appear on dmem_we_o in that cycle too. A new T and N can only be seen one cycle later, as dmem_addr_o and dmem_wdata_o. The bench's behavioural model follows the same timing. Between clock edges it compares the next-address and store outputs against the instruction being executed, and compares T and N against the state left by the previous instruction. That earlier instruction's requirement is named in any failure message.

// File: rtl/scpu_pkg.sv
package scpu_pkg;
  localparam int unsigned XLEN = 16;
  localparam int unsigned PCW  = 13;
  localparam int unsigned IMMW = 15;

  typedef enum logic [2:0] {
    CL_JMP  = 3'd0,
    CL_JZ   = 3'd1,
    CL_CALL = 3'd2,
    CL_ALU  = 3'd3,
    CL_LIT  = 3'd4
  } insn_cls_e;

  typedef enum logic [3:0] {
    OP_T     = 4'h0,
    OP_N     = 4'h1,
    OP_ADD   = 4'h2,
    OP_AND   = 4'h3,
    OP_OR    = 4'h4,
    OP_XOR   = 4'h5,
    OP_INV   = 4'h6,
    OP_EQ    = 4'h7,
    OP_SLT   = 4'h8,
    OP_SHR   = 4'h9,
    OP_DEC   = 4'hA,
    OP_RTOP  = 4'hB,
    OP_LOAD  = 4'hC,
    OP_SHL   = 4'hD,
    OP_DEPTH = 4'hE,
    OP_ULT   = 4'hF
  } alu_op_e;

  typedef struct packed {
    insn_cls_e        cls;
    logic             ret;
    alu_op_e          op;
    logic             t2n;
    logic             t2r;
    logic             st;
    logic [1:0]       dd;
    logic [1:0]       rd;
    logic [PCW-1:0]   tgt;
    logic [IMMW-1:0]  imm;
  } dec_t;
endpackage

// File: rtl/scpu_decode.sv
module scpu_decode
  import scpu_pkg::*;
(
  input  logic [XLEN-1:0] insn_i,
  output dec_t            dec_o
);
  always_comb begin
    dec_o.cls = insn_i[15] ? CL_LIT : insn_cls_e'({1'b0, insn_i[14:13]});
    dec_o.ret = insn_i[12];
    dec_o.op  = alu_op_e'(insn_i[11:8]);
    // bit 7 reserved, ignored
    dec_o.st  = insn_i[6];
    dec_o.t2r = insn_i[5];
    dec_o.t2n = insn_i[4];
    dec_o.rd  = insn_i[3:2];
    dec_o.dd  = insn_i[1:0];
    dec_o.tgt = insn_i[PCW-1:0];
    dec_o.imm = insn_i[IMMW-1:0];
  end
endmodule

// File: rtl/scpu_alu.sv
module scpu_alu
  import scpu_pkg::*;
#(
  parameter int unsigned PTRW = 4
) (
  input  alu_op_e         op_i,
  input  logic [XLEN-1:0] t_i,
  input  logic [XLEN-1:0] n_i,
  input  logic [XLEN-1:0] r_i,
  input  logic [XLEN-1:0] mem_i,
  input  logic [PTRW-1:0] dsp_i,
  output logic [XLEN-1:0] res_o
);
  logic eq_f, slt_f, ult_f;

  always_comb begin
    eq_f  = (n_i == t_i);
    slt_f = ($signed(n_i) < $signed(t_i));
    ult_f = (n_i < t_i);
    unique case (op_i)
      OP_T:     res_o = t_i;
      OP_N:     res_o = n_i;
      OP_ADD:   res_o = n_i + t_i;
      OP_AND:   res_o = n_i & t_i;
      OP_OR:    res_o = n_i | t_i;
      OP_XOR:   res_o = n_i ^ t_i;
      OP_INV:   res_o = ~t_i;
      OP_EQ:    res_o = {XLEN{eq_f}};
      OP_SLT:   res_o = {XLEN{slt_f}};
      OP_SHR:   res_o = {1'b0, t_i[XLEN-1:1]};
      OP_DEC:   res_o = t_i - XLEN'(1);
      OP_RTOP:  res_o = r_i;
      OP_LOAD:  res_o = mem_i;
      OP_SHL:   res_o = {t_i[XLEN-2:0], 1'b0};
      OP_DEPTH: res_o = XLEN'(dsp_i) + XLEN'(1);
      OP_ULT:   res_o = {XLEN{ult_f}};
      default:  res_o = t_i;
    endcase
  end
endmodule

// File: rtl/scpu_stack.sv
// Register-file stack; DEPTH must be a power of two so the pointer wraps.
module scpu_stack #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 16,
  localparam int unsigned PW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    delta_i,
  input  logic          we_i,
  input  logic [W-1:0]  wdata_i,
  output logic [PW-1:0] ptr_o,
  output logic [W-1:0]  top_o
);
  logic [PW-1:0] ptr_q, ptr_d;
  logic [W-1:0]  mem_q [DEPTH];

  assign ptr_d = ptr_q + PW'($signed(delta_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else         ptr_q <= ptr_d;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         mem_q[i] <= '0;
      else if (we_i && ptr_d == PW'(i))    mem_q[i] <= wdata_i;
    end
  end

  assign ptr_o = ptr_q;
  assign top_o = mem_q[ptr_q];
endmodule

// File: rtl/scpu_core.sv
module scpu_core
  import scpu_pkg::*;
#(
  parameter int unsigned DSTK_DEPTH = 16,
  parameter int unsigned RSTK_DEPTH = 16,
  localparam int unsigned DPW = $clog2(DSTK_DEPTH),
  localparam int unsigned RPW = $clog2(RSTK_DEPTH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [PCW-1:0]  imem_addr_o,
  input  logic [XLEN-1:0] imem_data_i,
  output logic [XLEN-1:0] dmem_addr_o,
  output logic [XLEN-1:0] dmem_wdata_o,
  output logic            dmem_we_o,
  input  logic [XLEN-1:0] dmem_rdata_i
);
  logic            fetch_q;
  logic [PCW-1:0]  pc_q, pc_d, pc_inc;
  logic [XLEN-1:0] t_q, t_d;
  logic [XLEN-1:0] n_top, r_top, alu_res, rs_wdata;
  logic [DPW-1:0]  dsp;
  logic [RPW-1:0]  rsp;
  logic [1:0]      ds_delta, rs_delta;
  logic            ds_we, rs_we, t_zero;
  dec_t            dec;

  scpu_decode u_dec (
    .insn_i (imem_data_i),
    .dec_o  (dec)
  );

  scpu_alu #(.PTRW(DPW)) u_alu (
    .op_i   (dec.op),
    .t_i    (t_q),
    .n_i    (n_top),
    .r_i    (r_top),
    .mem_i  (dmem_rdata_i),
    .dsp_i  (dsp),
    .res_o  (alu_res)
  );

  scpu_stack #(.DEPTH(DSTK_DEPTH), .W(XLEN)) u_dstk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .delta_i (ds_delta),
    .we_i    (ds_we),
    .wdata_i (t_q),
    .ptr_o   (dsp),
    .top_o   (n_top)
  );

  scpu_stack #(.DEPTH(RSTK_DEPTH), .W(XLEN)) u_rstk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .delta_i (rs_delta),
    .we_i    (rs_we),
    .wdata_i (rs_wdata),
    .ptr_o   (rsp),
    .top_o   (r_top)
  );

  assign pc_inc = pc_q + PCW'(1);
  assign t_zero = (t_q == '0);

  always_comb begin
    pc_d     = pc_q;
    t_d      = t_q;
    ds_delta = 2'b00;
    ds_we    = 1'b0;
    rs_delta = 2'b00;
    rs_we    = 1'b0;
    rs_wdata = t_q;
    if (fetch_q) begin
      unique case (dec.cls)
        CL_LIT: begin
          pc_d     = pc_inc;
          t_d      = XLEN'(dec.imm);
          ds_delta = 2'b01;
          ds_we    = 1'b1;
        end
        CL_JMP: pc_d = dec.tgt;
        CL_JZ: begin
          pc_d     = t_zero ? dec.tgt : pc_inc;
          t_d      = n_top;
          ds_delta = 2'b11;
        end
        CL_CALL: begin
          pc_d     = dec.tgt;
          rs_delta = 2'b01;
          rs_we    = 1'b1;
          rs_wdata = XLEN'(pc_inc);
        end
        CL_ALU: begin
          pc_d     = dec.ret ? r_top[PCW-1:0] : pc_inc;
          t_d      = alu_res;
          ds_delta = dec.dd;
          ds_we    = dec.t2n;
          rs_delta = dec.rd;
          rs_we    = dec.t2r;
        end
        default: pc_d = pc_inc;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fetch_q <= 1'b0;
      pc_q    <= '0;
      t_q     <= '0;
    end else begin
      fetch_q <= 1'b1;
      pc_q    <= pc_d;
      t_q     <= t_d;
    end
  end

  assign imem_addr_o  = pc_d;
  assign dmem_addr_o  = t_q;
  assign dmem_wdata_o = n_top;
  assign dmem_we_o    = fetch_q && dec.cls == CL_ALU && dec.st;
endmodule

// File: rtl/scpu_core_chk.sv
module scpu_core_chk #(
  parameter int unsigned DPW = 4,
  parameter int unsigned RPW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          fetch_q,
  input logic [15:0]   insn,
  input logic [12:0]   pc_q,
  input logic [15:0]   t_q,
  input logic [15:0]   n_top,
  input logic [15:0]   r_top,
  input logic [DPW-1:0] dsp,
  input logic [RPW-1:0] rsp,
  input logic          dmem_we_o
);
  logic is_lit, is_jmp, is_jz, is_call, is_alu;
  assign is_lit  = fetch_q && insn[15];
  assign is_jmp  = fetch_q && insn[15:13] == 3'b000;
  assign is_jz   = fetch_q && insn[15:13] == 3'b001;
  assign is_call = fetch_q && insn[15:13] == 3'b010;
  assign is_alu  = fetch_q && insn[15:13] == 3'b011;

  // R1
  bubble_no_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_q |-> !dmem_we_o);
  // R11
  fetch_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_q |=> fetch_q);
  // R2
  lit_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_lit |=> t_q == {1'b0, $past(insn[14:0])} && n_top == $past(t_q));
  // R10
  lit_dsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_lit |=> dsp == DPW'($past(dsp) + DPW'(1)));
  // R3
  jmp_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_jmp |=> pc_q == $past(insn[12:0]) && $stable(t_q) && $stable(dsp));
  // R4
  jz_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_jz |=> t_q == $past(n_top) && dsp == DPW'($past(dsp) - DPW'(1)));
  // R5
  call_link_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_call |=> r_top == 16'($past(pc_q)) + 16'd1 && rsp == RPW'($past(rsp) + RPW'(1)));
  // R9
  store_class_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dmem_we_o |-> is_alu && insn[6]);
  // R9
  spare_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_alu && insn[12:0] == 13'h0080 |=> $stable(t_q) && $stable(dsp) && $stable(n_top));
endmodule

bind scpu_core scpu_core_chk #(.DPW(DPW), .RPW(RPW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .fetch_q   (fetch_q),
  .insn      (imem_data_i),
  .pc_q      (pc_q),
  .t_q       (t_q),
  .n_top     (n_top),
  .r_top     (r_top),
  .dsp       (dsp),
  .rsp       (rsp),
  .dmem_we_o (dmem_we_o)
);

// File: tb/scpu_core_tb_top.sv
`timescale 1ns/1ps
module scpu_core_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [12:0] imem_addr_o;
  logic [15:0] imem_data_i, dmem_addr_o, dmem_wdata_o, dmem_rdata_i;
  logic        dmem_we_o;

  always #10 clk_i = ~clk_i;

  scpu_core dut_i (
    .clk_i, .rst_ni, .imem_addr_o, .imem_data_i,
    .dmem_addr_o, .dmem_wdata_o, .dmem_we_o, .dmem_rdata_i
  );

  logic [15:0] prog [512];
  logic [15:0] dram [256];
  always @(posedge clk_i) imem_data_i <= prog[imem_addr_o[8:0]];
  always @(posedge clk_i) if (dmem_we_o) dram[dmem_addr_o[7:0]] <= dmem_wdata_o;
  assign dmem_rdata_i = dram[dmem_addr_o[7:0]];

  int n_chk = 0, n_fail = 0, pa = 0;
  bit done = 0;

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic emit(logic [15:0] w); prog[pa] = w; pa++; endtask
  function automatic logic [15:0] lit(int v); return 16'h8000 | 16'(v & 16'h7fff); endfunction
  function automatic logic [15:0] br(int cls, int a); return 16'(cls << 13) | 16'(a & 16'h1fff); endfunction
  function automatic logic [15:0] alu(int op, bit ret = 0, bit tn = 0, bit tr = 0, bit st = 0,
                                      int dd = 0, int rd = 0);
    return {3'b011, ret, 4'(op), 1'b0, st, tr, tn, 2'(rd), 2'(dd)};
  endfunction

  function automatic string op_tag(logic [15:0] w);
    if (w[15]) return "R2";
    case (w[14:13])
      2'd0: return "R3";
      2'd1: return "R4";
      2'd2: return "R5";
      default: case (w[11:8])
        4'h7, 4'h8, 4'hF: return "R7";
        4'hB, 4'hC, 4'hE: return "R8";
        default:          return "R6";
      endcase
    endcase
  endfunction

  // behavioural reference state
  int          m_pc = 0, m_dsp = 0, m_rsp = 0;
  logic [15:0] m_t = 0;
  logic [15:0] m_ds [16], m_rs [16], m_mem [256];
  bit          m_valid = 0;
  string       t_tag = "R1", n_tag = "R1";

  task automatic model_cycle();
    logic [15:0] w, n, r, res;
    int dd, rd, npc;
    bit we;
    if (!m_valid) begin
      chk("R1", {3'b0, imem_addr_o}, 16'h0);
      chk("R1", {15'b0, dmem_we_o}, 16'h0);
      m_valid = 1;
      return;
    end
    w = prog[m_pc % 512]; n = m_ds[m_dsp]; r = m_rs[m_rsp];
    chk(t_tag, dmem_addr_o, m_t);
    chk(n_tag, dmem_wdata_o, n);
    we = 0; npc = (m_pc + 1) % 8192;
    if (w[15]) begin
      m_dsp = (m_dsp + 1) % 16; m_ds[m_dsp] = m_t; m_t = {1'b0, w[14:0]};
    end else if (w[14:13] == 2'd0) begin
      npc = w[12:0];
    end else if (w[14:13] == 2'd1) begin
      if (m_t == 0) npc = w[12:0];
      m_t = n; m_dsp = (m_dsp + 15) % 16;
    end else if (w[14:13] == 2'd2) begin
      m_rsp = (m_rsp + 1) % 16; m_rs[m_rsp] = 16'(m_pc + 1) & 16'h1fff; npc = w[12:0];
    end else begin
      case (w[11:8])
        4'h0: res = m_t;
        4'h1: res = n;
        4'h2: res = n + m_t;
        4'h3: res = n & m_t;
        4'h4: res = n | m_t;
        4'h5: res = n ^ m_t;
        4'h6: res = ~m_t;
        4'h7: res = (n == m_t) ? 16'hffff : 16'h0;
        4'h8: res = ($signed(n) < $signed(m_t)) ? 16'hffff : 16'h0;
        4'h9: res = m_t / 2;
        4'hA: res = m_t - 1;
        4'hB: res = r;
        4'hC: res = m_mem[m_t[7:0]];
        4'hD: res = m_t * 2;
        4'hE: res = 16'(m_dsp + 1);
        default: res = (n < m_t) ? 16'hffff : 16'h0;
      endcase
      dd = w[1] ? int'(w[1:0]) - 4 : int'(w[1:0]);
      rd = w[3] ? int'(w[3:2]) - 4 : int'(w[3:2]);
      if (w[12]) npc = r[12:0];
      if (w[6]) begin we = 1; m_mem[m_t[7:0]] = n; end
      m_dsp = (m_dsp + dd + 16) % 16;
      m_rsp = (m_rsp + rd + 16) % 16;
      if (w[4]) m_ds[m_dsp] = m_t;
      if (w[5]) m_rs[m_rsp] = m_t;
      m_t = res;
    end
    chk((w[15:13] == 3'b011 && w[12]) ? "R5" : (w[15] ? "R11" : op_tag(w)),
        {3'b0, imem_addr_o}, 16'(npc));
    chk("R9", {15'b0, dmem_we_o}, {15'b0, we});
    m_pc  = npc;
    t_tag = op_tag(w);
    n_tag = (w[15:13] == 3'b011) ? ((w[4] || w[7]) ? "R9" : "R10") : op_tag(w);
  endtask

  task automatic build_prog();
    for (int i = 0; i < 512; i++) prog[i] = 16'h0000;
    emit(lit(5)); emit(lit(3)); emit(alu(2, .dd(-1)));
    emit(lit(8)); emit(alu(7, .dd(-1))); emit(alu(6));
    emit(br(1, pa + 2)); emit(lit(1));
    emit(lit(7)); emit(br(1, 300));
    emit(lit(2)); emit(alu(6)); emit(lit(1)); emit(alu(8, .dd(-1)));
    emit(lit(2)); emit(alu(6)); emit(lit(1)); emit(alu(15, .dd(-1)));
    emit(lit(1)); emit(lit(2)); emit(alu(15, .dd(-1)));
    emit(lit(16'h1234)); emit(lit(16'h40)); emit(alu(0, .st(1), .dd(-1)));
    emit(alu(1, .dd(-1))); emit(lit(16'h40)); emit(alu(12));
    emit(lit(16'h0f0f)); emit(alu(3, .dd(-1))); emit(lit(16'h00ff)); emit(alu(4, .dd(-1)));
    emit(lit(16'h3333)); emit(alu(5, .dd(-1))); emit(alu(9)); emit(alu(13)); emit(alu(10));
    emit(alu(1)); emit(alu(14, .tn(1), .dd(1)));
    emit(lit(9)); emit(alu(0, .tr(1), .rd(1), .dd(-1))); emit(alu(11, .tn(1), .dd(1), .rd(-1)));
    emit(br(2, 200));
    emit(alu(0) | 16'h0080); emit(alu(1, .dd(-2)));
    for (int i = 0; i < 20; i++) emit(lit(i + 100));
    emit(alu(14, .tn(1), .dd(1)));
    for (int i = 0; i < 21; i++) emit(alu(1, .dd(-1)));
    emit(br(0, pa));
    pa = 200; emit(alu(2, .dd(-1))); emit(br(2, 210)); emit(alu(0, .ret(1), .rd(-1)));
    pa = 210; emit(lit(16'h55)); emit(alu(10, .ret(1), .rd(-1)));
  endtask

  task automatic summary();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R11: watchdog, actual hung expected finished");
      summary();
    end
  end

  initial begin
    build_prog();
    for (int i = 0; i < 256; i++) begin dram[i] = 0; m_mem[i] = 0; end
    for (int i = 0; i < 16; i++) begin m_ds[i] = 0; m_rs[i] = 0; end
    repeat (3) @(negedge clk_i);
    chk("R1", {3'b0, imem_addr_o}, 16'h0);
    chk("R1", dmem_addr_o, 16'h0);
    chk("R1", dmem_wdata_o, 16'h0);
    chk("R1", {15'b0, dmem_we_o}, 16'h0);
    rst_ni = 1'b1;
    for (int c = 0; c < 300; c++) begin
      model_cycle();
      @(negedge clk_i);
    end
    summary();
  end
endmodule